// File: doc/BRIEF.md
# Dual I/O Flash Read Responder

This block plays the memory side of a serial flash link during two-bit-wide reads. It samples chip select, serial clock and both data lines with its own system clock, then walks one frame at a time through the phases of a read. First comes an 8-bit opcode on line 0. Next is an address moved two bits per serial clock. Then comes a latency window whose first four clocks carry a mode byte. Finally it returns bytes from a 256-entry internal array, two bits per serial clock, until the host deselects it.

A configuration input picks a 24-bit or 32-bit address, and this also sets the latency length. The mode byte decides whether the next frame may skip the opcode (continuous mode). The state machine has six states. `ST_IDLE` holds while deselected. `ST_CMD` shifts the opcode. `ST_ADDR` shifts the address. `ST_LAT` counts latency and captures the mode. `ST_DATA` drives read data. `ST_IGNORE` absorbs the rest of a frame with an unknown opcode. Transitions:
- A select going low moves `ST_IDLE` to `ST_ADDR` in continuous mode, and to `ST_CMD` otherwise.
- `ST_CMD` goes to `ST_ADDR` on a match after eight bits, and to `ST_IGNORE` on a mismatch.
- `ST_ADDR` goes to `ST_LAT` after the last address clock.
- `ST_LAT` goes to `ST_DATA` after the last latency clock.
- Any state returns to `ST_IDLE` when the select goes high.

Top module: `dio_read_resp`

## Requirements
- R1: After reset the output enables are 00, the output lines are 00, and the block is in normal (opcode-first) mode.
- R2: In normal mode the first 8 serial clock rising edges sample line 0, MSB first. Opcode 8'hBB starts the address phase. The address is shifted MSB first, two bits per rising edge, with line 1 carrying the higher (odd) bit of each pair.
- R3: With `addr_wide`=0 the address is 24 bits (12 clocks) and the latency is 4 clocks. With `addr_wide`=1 the address is 32 bits (16 clocks) and the latency is 6 clocks.
- R4: The mode byte is taken from the first four latency clocks, MSB first, with line 1 carrying the odd bit of each pair. Any further latency clocks are don't-care.
- R5: After the last latency rising edge, each serial clock falling edge drives the next bit pair of the current byte: bits 7:6, then 5:4, then 3:2, then 1:0. Line 1 carries the higher bit of each pair.
- R6: The byte at array index i is (37*i + 11) mod 256. Only the low 8 address bits select the index.
- R7: After the fourth pair of a byte the address increments by one. Index 255 is followed by index 0.
- R8: If a frame completed all four mode clocks with mode bits 7:4 equal to 4'hA, the next frame starts directly with the address phase.
- R9: If a frame ends before its mode byte is complete, or its mode bits 7:4 are not 4'hA, the next frame starts with an opcode. A short select pulse of eight or fewer clocks therefore leaves continuous mode.
- R10: The two output enables are always equal. They are 11 only in the data phase while selected, and 00 within two system clocks after the select goes high.
- R11: An opcode other than 8'hBB leaves the outputs disabled until the select goes high. That frame also ends continuous mode.
- R12: The output lines change only in response to a serial clock falling edge. They hold steady across rising edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_wide | input | 1 | 0: 24-bit address, 4 latency clocks; 1: 32-bit address, 6 latency clocks |
| spi_cs_n | input | 1 | Active-low chip select from the host |
| spi_sclk | input | 1 | Serial clock from the host, idle low |
| spi_io_in | input | 2 | Data lines as driven by the host (bit 1 = odd bit) |
| spi_io_out | output | 2 | Data lines as driven by this block |
| spi_io_oe | output | 2 | Output enables for the two data lines |

## Verification
The bench aims at the address wrap from index 255 to 0. A responder that fails to step, or carries into bits it should mask, returns the wrong byte there. It checks 32-bit addresses with nonzero upper bits, which catch a block that uses the full address as the index or miscounts the longer latency. Continuous mode is entered and left three ways: through a mode nibble other than A, through a short select pulse, and through an unknown opcode. A block that keeps the mode too long reads the next opcode as address bits and returns wrong data; one that drops it too early treats the address as an opcode and stays silent. Swapped line order in the address or mode pairs shows up as wrong bytes or a missed continuous frame.

// File: rtl/dio_rd_pkg.sv
package dio_rd_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_ADDR,
        ST_LAT,
        ST_DATA,
        ST_IGNORE
    } dio_state_e;

    localparam logic [7:0] OPC_DUAL_READ = 8'hBB;
    localparam logic [3:0] CONT_KEY      = 4'hA;
    localparam int         MODE_CLKS     = 4;
endpackage

// File: rtl/dio_pin_sample.sv
module dio_pin_sample (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_n_in,
    input  logic       sclk_in,
    input  logic [1:0] io_in,
    output logic       cs_q,
    output logic [1:0] io_q,
    output logic       sclk_rise,
    output logic       sclk_fall,
    output logic       cs_rise
);
    logic sclk_q, sclk_qq, cs_qq;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_q  <= 1'b0;
            sclk_qq <= 1'b0;
            cs_q    <= 1'b1;
            cs_qq   <= 1'b1;
            io_q    <= 2'b00;
        end else begin
            sclk_q  <= sclk_in;
            sclk_qq <= sclk_q;
            cs_q    <= cs_n_in;
            cs_qq   <= cs_q;
            io_q    <= io_in;
        end
    end

    assign sclk_rise = sclk_q & ~sclk_qq;
    assign sclk_fall = ~sclk_q & sclk_qq;
    assign cs_rise   = cs_q & ~cs_qq;
endmodule

// File: rtl/dio_byte_rom.sv
module dio_byte_rom #(
    parameter int IDX_W = 8
) (
    input  logic [IDX_W-1:0] idx,
    output logic [7:0]       data
);
    logic [IDX_W+7:0] prod;

    always_comb begin
        prod = (IDX_W + 8)'(idx) * (IDX_W + 8)'(37) + (IDX_W + 8)'(11);
        data = prod[7:0];
    end
endmodule

// File: rtl/dio_read_resp.sv
module dio_read_resp
    import dio_rd_pkg::*;
#(
    parameter int NARROW_BITS = 24,
    parameter int WIDE_BITS   = 32,
    parameter int LAT_NARROW  = 4,
    parameter int LAT_WIDE    = 6,
    parameter int ARRAY_DEPTH = 256
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       addr_wide,
    input  logic       spi_cs_n,
    input  logic       spi_sclk,
    input  logic [1:0] spi_io_in,
    output logic [1:0] spi_io_out,
    output logic [1:0] spi_io_oe
);
    localparam int ADDR_W = WIDE_BITS;
    localparam int IDX_W  = $clog2(ARRAY_DEPTH);
    localparam int CNT_W  = 6;

    logic       cs_q, sclk_rise, sclk_fall, cs_rise;
    logic [1:0] io_q;

    dio_state_e        state_q, state_d;
    logic [CNT_W-1:0]  cnt_q, addr_last, lat_last;
    logic [7:0]        opc_q, mode_q, out_sh_q, rom_data;
    logic [ADDR_W-1:0] addr_q;
    logic              mode_done_q, cont_q;
    logic [1:0]        pair_q, io_out_q;

    dio_pin_sample u_pins (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n_in   (spi_cs_n),
        .sclk_in   (spi_sclk),
        .io_in     (spi_io_in),
        .cs_q      (cs_q),
        .io_q      (io_q),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .cs_rise   (cs_rise)
    );

    dio_byte_rom #(.IDX_W(IDX_W)) u_rom (
        .idx  (addr_q[IDX_W-1:0]),
        .data (rom_data)
    );

    assign addr_last = addr_wide ? CNT_W'(WIDE_BITS / 2 - 1) : CNT_W'(NARROW_BITS / 2 - 1);
    assign lat_last  = addr_wide ? CNT_W'(LAT_WIDE - 1)      : CNT_W'(LAT_NARROW - 1);

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (cs_q) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:   state_d = cont_q ? ST_ADDR : ST_CMD;
                ST_CMD:    if (sclk_rise && cnt_q == CNT_W'(7))
                               state_d = ({opc_q[6:0], io_q[0]} == OPC_DUAL_READ) ? ST_ADDR : ST_IGNORE;
                ST_ADDR:   if (sclk_rise && cnt_q == addr_last) state_d = ST_LAT;
                ST_LAT:    if (sclk_rise && cnt_q == lat_last)  state_d = ST_DATA;
                ST_DATA:   state_d = ST_DATA;
                ST_IGNORE: state_d = ST_IGNORE;
                default:   state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q       <= '0;
            opc_q       <= '0;
            addr_q      <= '0;
            mode_q      <= '0;
            mode_done_q <= 1'b0;
            cont_q      <= 1'b0;
            pair_q      <= '0;
            out_sh_q    <= '0;
            io_out_q    <= '0;
        end else begin
            if (state_d != state_q) cnt_q <= '0;
            else if (sclk_rise)     cnt_q <= cnt_q + CNT_W'(1);

            if (state_q == ST_IDLE && !cs_q) begin
                addr_q      <= '0;
                mode_done_q <= 1'b0;
            end

            if (state_q == ST_CMD && sclk_rise)
                opc_q <= {opc_q[6:0], io_q[0]};

            if (state_q == ST_ADDR && sclk_rise)
                addr_q <= {addr_q[ADDR_W-3:0], io_q};

            if (state_q == ST_LAT && sclk_rise && cnt_q < CNT_W'(MODE_CLKS)) begin
                mode_q <= {mode_q[5:0], io_q};
                if (cnt_q == CNT_W'(MODE_CLKS - 1)) mode_done_q <= 1'b1;
            end

            if (state_q == ST_LAT && state_d == ST_DATA)
                pair_q <= '0;

            if (state_q == ST_DATA && !cs_q && sclk_fall) begin
                if (pair_q == 2'd0) begin
                    io_out_q <= rom_data[7:6];
                    out_sh_q <= {rom_data[5:0], 2'b00};
                end else begin
                    io_out_q <= out_sh_q[7:6];
                    out_sh_q <= {out_sh_q[5:0], 2'b00};
                end
                if (pair_q == 2'd3) addr_q <= addr_q + ADDR_W'(1);
                pair_q <= pair_q + 2'd1;
            end

            if (cs_rise)
                cont_q <= mode_done_q && (mode_q[7:4] == CONT_KEY);
        end
    end

    // outputs
    always_comb begin
        spi_io_oe  = (state_q == ST_DATA && !cs_q) ? 2'b11 : 2'b00;
        spi_io_out = io_out_q;
    end
endmodule

// File: rtl/dio_read_resp_chk.sv
module dio_read_resp_chk
    import dio_rd_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              spi_cs_n,
    input logic [1:0]        spi_io_out,
    input logic [1:0]        spi_io_oe,
    input dio_state_e        state_q,
    input logic              cs_q,
    input logic              sclk_fall,
    input logic              cs_rise,
    input logic [1:0]        pair_q,
    input logic [ADDR_W-1:0] addr_q,
    input logic              cont_q
);
    assert_oe_off_deselected_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(spi_cs_n) |-> spi_io_oe == 2'b00);

    assert_oe_pair_equal_R10: assert property (@(posedge clk) disable iff (!rst_n)
        spi_io_oe == 2'b00 || spi_io_oe == 2'b11);

    assert_out_only_on_fall_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !sclk_fall |=> $stable(spi_io_out));

    assert_ignore_silent_R11: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_IGNORE |-> spi_io_oe == 2'b00);

    assert_addr_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DATA && !cs_q && sclk_fall && pair_q == 2'd3)
        |=> addr_q == $past(addr_q) + ADDR_W'(1));

    assert_cont_changes_at_deselect_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_rise |=> $stable(cont_q));
endmodule

bind dio_read_resp dio_read_resp_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .spi_cs_n   (spi_cs_n),
    .spi_io_out (spi_io_out),
    .spi_io_oe  (spi_io_oe),
    .state_q    (state_q),
    .cs_q       (cs_q),
    .sclk_fall  (sclk_fall),
    .cs_rise    (cs_rise),
    .pair_q     (pair_q),
    .addr_q     (addr_q),
    .cont_q     (cont_q)
);

// File: tb/dio_read_resp_tb_top.sv
`timescale 1ns/1ps
module dio_read_resp_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       addr_wide = 1'b0;
    logic       cs_n = 1'b1;
    logic       sclk = 1'b0;
    logic [1:0] io_in = 2'b00;
    logic [1:0] io_out, io_oe;

    int  n_checks = 0;
    int  n_errors = 0;
    bit  done = 1'b0;
    bit  model_cont = 1'b0;

    always #2.5 clk = ~clk;

    dio_read_resp dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr_wide  (addr_wide),
        .spi_cs_n   (cs_n),
        .spi_sclk   (sclk),
        .spi_io_in  (io_in),
        .spi_io_out (io_out),
        .spi_io_oe  (io_oe)
    );

    function automatic logic [7:0] exp_byte(input logic [31:0] a);
        logic [15:0] p;
        p = 16'(a[7:0]) * 16'd37 + 16'd11;
        return p[7:0];
    endfunction

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic spi_clk(input logic [1:0] d);
        sclk = 1'b0; io_in = d; tick(4);
        sclk = 1'b1; tick(4);
    endtask

    task automatic send_cmd(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) spi_clk({1'b0, b[i]});
    endtask

    task automatic send_addr(input logic [31:0] a, input bit wide);
        for (int i = (wide ? 31 : 23); i >= 1; i -= 2) spi_clk({a[i], a[i-1]});
    endtask

    task automatic send_lat(input logic [7:0] m, input bit wide);
        for (int i = 7; i >= 1; i -= 2) spi_clk({m[i], m[i-1]});
        if (wide) begin
            spi_clk(2'b00);
            spi_clk(2'b00);
        end
    endtask

    task automatic read_bytes(input logic [31:0] start, input int n);
        for (int b = 0; b < n; b++) begin
            logic [7:0] exp, got;
            exp = exp_byte(start + 32'(b));
            got = '0;
            for (int p = 0; p < 4; p++) begin
                logic [1:0] pr;
                sclk = 1'b0; io_in = 2'b00; tick(4);
                pr = io_out;
                got = {got[5:0], pr};
                if (p == 0) chk(io_oe == 2'b11, "R10 oe in data phase", 32'(io_oe), 32'h3);
                sclk = 1'b1; tick(4);
                chk(io_out == pr, "R12 hold across rise", 32'(io_out), 32'(pr));
            end
            chk(got == exp, "R5/R6/R7 data byte", 32'(got), 32'(exp));
        end
    endtask

    task automatic end_frame();
        cs_n = 1'b1; sclk = 1'b0; io_in = 2'b00; tick(3);
        chk(io_oe == 2'b00, "R10 oe off after deselect", 32'(io_oe), 32'h0);
        tick(3);
    endtask

    task automatic read_frame(input logic [31:0] a, input logic [7:0] m, input bit wide, input int n);
        addr_wide = wide;
        cs_n = 1'b0; tick(4);
        if (!model_cont) send_cmd(8'hBB);
        send_addr(a, wide);
        send_lat(m, wide);
        read_bytes(a, n);
        end_frame();
        model_cont = (m[7:4] == 4'hA);
    endtask

    initial begin
        tick(1);
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++; n_errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED1234));
        tick(4);
        rst_n = 1'b1;
        tick(4);
        // R1 reset state
        chk(io_oe == 2'b00, "R1 reset oe", 32'(io_oe), 32'h0);
        chk(io_out == 2'b00, "R1 reset out", 32'(io_out), 32'h0);

        // R1/R2/R3/R5/R6 first frame needs opcode (normal mode)
        read_frame(32'h0000_0010, 8'h00, 1'b0, 2);
        // R7 wrap
        read_frame(32'h0012_34FE, 8'h31, 1'b0, 4);
        // R3/R6 wide address with high bits set
        read_frame(32'hABCD_EF10, 8'h00, 1'b1, 3);
        // R4/R8 enter continuous, then address-first frame
        read_frame(32'h0000_0040, 8'hA3, 1'b0, 1);
        read_frame(32'h0000_0080, 8'h5F, 1'b0, 2);   // R8 skip opcode; R9 exit by nibble
        read_frame(32'h0000_00C0, 8'hA0, 1'b1, 1);   // R9 opcode needed again; R8 enter wide
        read_frame(32'h7700_00FF, 8'hAF, 1'b1, 2);   // R8 wide continuous, R7 wrap

        // R9 short pulse leaves continuous mode
        cs_n = 1'b0; tick(4);
        spi_clk(2'b11); spi_clk(2'b01); spi_clk(2'b10);
        end_frame();
        model_cont = 1'b0;
        read_frame(32'h0000_0022, 8'h00, 1'b0, 2);   // R9 opcode frame after pulse

        // R11 unknown opcode is ignored
        addr_wide = 1'b0;
        cs_n = 1'b0; tick(4);
        send_cmd(8'h03);
        for (int i = 0; i < 20; i++) begin
            spi_clk(2'(i));
            chk(io_oe == 2'b00, "R11 ignored opcode no drive", 32'(io_oe), 32'h0);
        end
        end_frame();
        model_cont = 1'b0;
        read_frame(32'h0000_0005, 8'h00, 1'b0, 1);   // R11 normal decode resumes

        // random frames
        for (int f = 0; f < 30; f++) begin
            logic [31:0] a;
            logic [7:0]  m;
            bit          w;
            a = $urandom;
            m = 8'($urandom);
            w = 1'($urandom % 2);
            if ($urandom % 2 == 0) m[7:4] = 4'hA;
            else if (m[7:4] == 4'hA) m[7:4] = 4'h5;
            if (!w) a[31:24] = 8'h00;
            read_frame(a, m, w, 1 + int'($urandom % 4));
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule